// File: doc/BRIEF.md
# Wheel-Stall Detector

The block watches a wheel that is expected to keep turning. Two single-cycle pulse inputs feed it. One pulse arrives each time the wheel advances by a small step. The other is a periodic time tick, nominally every 10 ms. When a set number of ticks go by with no wheel pulse, the wheel is taken to have locked up. The block then raises a release output for one clock cycle, so that a downstream brake controller can let the wheel go.

After every release the block stays in a holdoff phase, and wheel pulses cannot rearm it there. The holdoff lasts for a set number of ticks. Once it ends, the block starts watching again from a tick count of zero. As a result, two releases are always at least `STALL_TICKS + HOLD_TICKS` ticks apart. With the defaults of two and two, that spacing is four ticks.

Top module: `wheel_stall_detector`

## Requirements
- R1: While `rst` is high, and in the cycle after it is taken low, `release_o` is 0. Reset leaves the block watching for stalls with a tick count of zero, so the first release needs `STALL_TICKS` ticks.
- R2: While watching, the `STALL_TICKS`-th tick with no wheel pulse since the last clear sets `release_o` high in the cycle after that tick is sampled.
- R3: `release_o` is high for exactly one clock cycle per release.
- R4: While watching, a wheel pulse resets the tick count to zero. `STALL_TICKS` further ticks are then needed for a release.
- R5: While watching, a wheel pulse and a tick in the same cycle leave the count at zero. The wheel pulse takes precedence.
- R6: After a release, `release_o` stays 0 until `HOLD_TICKS` ticks have been seen. Wheel pulses in this holdoff have no effect on the holdoff or on the later count.
- R7: When the holdoff ends, watching resumes with a count of zero. The next release needs a full `STALL_TICKS` ticks after the last holdoff tick.
- R8: Consecutive releases are separated by at least `STALL_TICKS + HOLD_TICKS` ticks, counting the tick that triggers the later release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wheel_i | input | 1 | One-cycle pulse per small wheel rotation |
| tick_i | input | 1 | One-cycle periodic time tick |
| release_o | output | 1 | Registered one-cycle release pulse |

## Verification
The bench builds the block with `STALL_TICKS = 3` and `HOLD_TICKS = 2`. Because the two thresholds differ, a design that swapped them would be caught, as would one that shared a single hard-wired limit. A design that counted the holdoff into the next stall window would also be caught. The bench compresses the tick period to a few clock cycles, so long tick-only streams fit in the run. These streams show the release-to-release spacing of five ticks.

// File: rtl/stall_pkg.sv
package stall_pkg;

    typedef enum logic [1:0] {
        PH_WATCH   = 2'd0,
        PH_RELEASE = 2'd1,
        PH_HOLDOFF = 2'd2
    } phase_e;

    typedef struct packed {
        logic clear;
        logic incr;
    } cnt_ctrl_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/stall_tick_counter.sv
module stall_tick_counter
    import stall_pkg::*;
#(
    parameter int unsigned LIMIT = 2,
    localparam int unsigned CW = cnt_width(LIMIT)
) (
    input  logic          clk,
    input  logic          rst,
    input  cnt_ctrl_t     ctrl,
    output logic [CW-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (ctrl.clear) begin
            count <= '0;
        end else if (ctrl.incr) begin
            count <= count + 1'b1;
        end
    end

    // The count never reaches the larger of the two thresholds (R8 window)
    p_count_bound_r8: assert property (@(posedge clk) disable iff (rst)
        32'(count) < LIMIT);

endmodule

// File: rtl/stall_phase_fsm.sv
module stall_phase_fsm
    import stall_pkg::*;
#(
    parameter int unsigned STALL_TICKS = 2,
    parameter int unsigned HOLD_TICKS  = 2,
    parameter int unsigned CW          = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wheel_i,
    input  logic          tick_i,
    input  logic [CW-1:0] count,
    output cnt_ctrl_t     ctrl,
    output phase_e        phase,
    output logic          release_o
);

    localparam logic [CW-1:0] STALL_LAST = CW'(STALL_TICKS - 1);
    localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_TICKS - 1);

    phase_e phase_nx;

    always_comb begin
        phase_nx   = phase;
        ctrl.clear = 1'b0;
        ctrl.incr  = 1'b0;
        unique case (phase)
            PH_WATCH: begin
                if (wheel_i) begin
                    ctrl.clear = 1'b1;
                end else if (tick_i) begin
                    if (count == STALL_LAST) begin
                        ctrl.clear = 1'b1;
                        phase_nx   = PH_RELEASE;
                    end else begin
                        ctrl.incr = 1'b1;
                    end
                end
            end
            PH_RELEASE: begin
                if (tick_i && HOLD_TICKS == 1) begin
                    ctrl.clear = 1'b1;
                    phase_nx   = PH_WATCH;
                end else begin
                    ctrl.incr = tick_i;
                    phase_nx  = PH_HOLDOFF;
                end
            end
            PH_HOLDOFF: begin
                if (tick_i) begin
                    if (count == HOLD_LAST) begin
                        ctrl.clear = 1'b1;
                        phase_nx   = PH_WATCH;
                    end else begin
                        ctrl.incr = 1'b1;
                    end
                end
            end
            default: begin
                ctrl.clear = 1'b1;
                phase_nx   = PH_WATCH;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_WATCH;
            release_o <= 1'b0;
        end else begin
            phase     <= phase_nx;
            release_o <= (phase_nx == PH_RELEASE);
        end
    end

    p_release_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
        release_o |=> !release_o);

    p_release_after_tick_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WATCH && tick_i && !wheel_i && count == STALL_LAST) |=> release_o);

    p_wheel_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WATCH && wheel_i) |=> (count == '0 && !release_o));

    p_wheel_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WATCH && wheel_i && tick_i) |=> (phase == PH_WATCH && count == '0));

    p_hold_ignores_wheel_r6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HOLDOFF && wheel_i && !tick_i) |=> (phase == PH_HOLDOFF && $stable(count)));

    p_resume_from_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_WATCH) |=> (phase == PH_WATCH) |-> (count == '0));

endmodule

// File: rtl/wheel_stall_detector.sv
module wheel_stall_detector
    import stall_pkg::*;
#(
    parameter int unsigned STALL_TICKS = 2,
    parameter int unsigned HOLD_TICKS  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wheel_i,
    input  logic tick_i,
    output logic release_o
);

    localparam int unsigned LIMIT = max2(STALL_TICKS, HOLD_TICKS);
    localparam int unsigned CW    = cnt_width(LIMIT);

    cnt_ctrl_t     ctrl;
    logic [CW-1:0] count;
    phase_e        phase;

    stall_tick_counter #(
        .LIMIT (LIMIT)
    ) u_counter (
        .clk   (clk),
        .rst   (rst),
        .ctrl  (ctrl),
        .count (count)
    );

    stall_phase_fsm #(
        .STALL_TICKS (STALL_TICKS),
        .HOLD_TICKS  (HOLD_TICKS),
        .CW          (CW)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .wheel_i   (wheel_i),
        .tick_i    (tick_i),
        .count     (count),
        .ctrl      (ctrl),
        .phase     (phase),
        .release_o (release_o)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> !release_o);

endmodule

// File: tb/wheel_stall_detector_bench.sv
module wheel_stall_detector_bench;

    localparam int STALL = 3;
    localparam int HOLD  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wheel_i = 1'b0;
    logic tick_i = 1'b0;
    logic release_o;

    always #4 clk = ~clk;

    wheel_stall_detector #(
        .STALL_TICKS (STALL),
        .HOLD_TICKS  (HOLD)
    ) u_wheel_stall_detector (
        .clk       (clk),
        .rst       (rst),
        .wheel_i   (wheel_i),
        .tick_i    (tick_i),
        .release_o (release_o)
    );

    typedef struct {
        logic  exp;
        string req;
    } item_t;

    item_t q[$];
    int n_checks = 0;
    int n_fail   = 0;

    // reference model state
    int  m_mode  = 0;   // 0 watch, 1 release, 2 holdoff
    int  m_ticks = 0;
    int  m_hold  = 0;

    task automatic step(input logic w, input logic t, input logic r, input string req);
        logic e;
        @(negedge clk);
        rst = r; wheel_i = w; tick_i = t;
        e = 1'b0;
        if (r) begin
            m_mode = 0; m_ticks = 0; m_hold = 0;
        end else if (m_mode == 1) begin
            m_hold = HOLD - (t ? 1 : 0);
            if (m_hold == 0) begin m_mode = 0; m_ticks = 0; end
            else m_mode = 2;
        end else if (m_mode == 2) begin
            if (t) begin
                m_hold--;
                if (m_hold == 0) begin m_mode = 0; m_ticks = 0; end
            end
        end else begin
            if (w) m_ticks = 0;
            else if (t) begin
                m_ticks++;
                if (m_ticks == STALL) begin
                    e = 1'b1; m_mode = 1; m_ticks = 0;
                end
            end
        end
        q.push_back('{exp: e, req: req});
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, req);
    endtask

    task automatic tick(input string req);
        step(1'b0, 1'b1, 1'b0, req);
        idle(2, req);
    endtask

    // monitor: compare one expected item per clock, 1 ns after the edge
    int  sp_ticks = 0;
    bit  sp_seen  = 0;
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_checks++;
            if (release_o !== it.exp) begin
                n_fail++;
                $display("FAIL %s: release_o=%b expected %b at %0t", it.req, release_o, it.exp, $time);
            end
        end
        if (rst) begin
            sp_ticks = 0; sp_seen = 0;
        end else begin
            if (tick_i) sp_ticks++;
            if (release_o === 1'b1) begin
                if (sp_seen) begin
                    n_checks++;
                    if (sp_ticks < STALL + HOLD) begin
                        n_fail++;
                        $display("FAIL R8: spacing %0d ticks expected >= %0d", sp_ticks, STALL + HOLD);
                    end
                end
                sp_seen = 1; sp_ticks = 0;
            end
        end
    end

    initial begin
        #(200000 * 8);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R1: reset quiet, and count starts at zero
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1, "R1");
        idle(2, "R1");
        tick("R1"); tick("R1");
        // R2/R3: third tick gives a one-cycle release
        tick("R2"); idle(3, "R3");
        // R6: wheel pulses in holdoff are ignored
        step(1'b1, 1'b0, 1'b0, "R6");
        tick("R6");
        step(1'b1, 1'b0, 1'b0, "R6");
        tick("R6");
        // R7: full stall window after holdoff
        tick("R7"); tick("R7"); tick("R7");
        idle(2, "R7");
        // holdoff, then R4: wheel clears count
        tick("R6"); tick("R6");
        tick("R4"); tick("R4");
        step(1'b1, 1'b0, 1'b0, "R4");
        tick("R4"); tick("R4"); tick("R4");
        // holdoff, then R5: simultaneous wheel and tick
        tick("R6"); tick("R6");
        tick("R5"); tick("R5");
        step(1'b1, 1'b1, 1'b0, "R5"); idle(2, "R5");
        tick("R5"); tick("R5"); tick("R5");
        // R8: long tick-only stream
        for (int i = 0; i < 25; i++) tick("R8");
        // reset in mid-count then restart (R1)
        tick("R1");
        step(1'b0, 1'b0, 1'b1, "R1");
        tick("R1"); tick("R1"); tick("R2");
        idle(4, "R3");
        @(negedge clk);
        @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule